// File: doc/BRIEF.md
# Semaphore Poll-Min Writeback Engine

The engine takes one command at a time. A command names a block of consecutive 32-bit semaphore words, a second block that receives copies, a word count, a fold code and a destination register index. The engine reads the words one by one over a single-outstanding memory request/response port. It folds them into their unsigned minimum. If that minimum is nonzero, it writes one copy of it into each word of the writeback block, so every semaphore can be lowered by the common amount. It then presents the minimum and the register index on a completion port, where a control program can branch on the value.

A command that fails the legality check makes no memory access. It completes at once with the error bit set. The engine is busy from the cycle it accepts a command until its completion has been acknowledged.

Top module: `sem_pollmin_engine`

## Requirements
- R1: After reset, `cmd_ready_o` is 1 and `mem_req_o` and `done_valid_o` are 0.
- R2: A command is legal only if all of the following hold: the count is between 1 and 16 inclusive, bits [1:0] of both addresses are 0, and the fold code is 8'h09 (minimum). An illegal command issues no memory request and completes with `done_err_o`=1 and `done_result_o`=0.
- R3: Reads go out one at a time, to read_addr+4·i for i = 0 up to count−1 in ascending order. Each request holds its address and type until `mem_rsp_i`, and the next request follows only after that response.
- R4: The result is the minimum of the words read, with every word compared as an unsigned 32-bit value. The accumulator starts at the first word.
- R5: When the result is nonzero, the engine writes it after all reads, exactly count times, to wb_addr+4·i for i = 0 up to count−1.
- R6: When the result is zero, the engine makes no write.
- R7: On completion, `done_valid_o` rises with `done_err_o`=0, the result, and the command's register index. All of these hold steady until `done_ready_i` is seen high.
- R8: `cmd_ready_o` is 0 from the accepting clock edge until the cycle after the completion handshake. A command offered while the engine is busy is never taken.
- R9: The boundary counts 1 and 16 both complete correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Engine idle; command taken when both high |
| cmd_rd_addr_i | input | ADDR_W | Byte address of first semaphore word |
| cmd_wb_addr_i | input | ADDR_W | Byte address of first writeback word |
| cmd_count_i | input | CNT_W | Number of words (legal 1..MAX_CNT) |
| cmd_op_i | input | OP_W | Fold code; 8'h09 = minimum |
| cmd_reg_i | input | REG_W | Destination register index |
| mem_req_o | output | 1 | Memory request, held until response |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | ADDR_W | Request byte address |
| mem_wdata_o | output | DATA_W | Write data |
| mem_rsp_i | input | 1 | Response for the pending request |
| mem_rdata_i | input | DATA_W | Read data, valid with response |
| done_valid_o | output | 1 | Completion present |
| done_ready_i | input | 1 | Completion acknowledge |
| done_result_o | output | DATA_W | Folded minimum |
| done_reg_o | output | REG_W | Register index of the command |
| done_err_o | output | 1 | Command was illegal |

## Verification
Two events can coincide: the acknowledge of a completion and a new command already waiting on the command port. The bench keeps a completion pending for several cycles, then raises `done_ready_i` and `cmd_valid_i` in the same cycle. It checks that `cmd_ready_o` is still low in that cycle and rises only in the next. The second command must then run and complete with its own register index and result. A further test holds an illegal command on the port while the engine is mid-run, and checks that it never produces a second completion.

// File: rtl/sem_pollmin_pkg.sv
package sem_pollmin_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_DONE  = 2'd3
  } eng_state_e;

  localparam int unsigned FOLD_MIN_CODE = 32'h09;
  localparam int unsigned WORD_BYTES_LOG2 = 2;
endpackage

// File: rtl/sem_cmd_check.sv
module sem_cmd_check
  import sem_pollmin_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int MAX_CNT = 16,
  parameter int OP_W    = 8,
  parameter int CNT_W   = 5
) (
  input  logic [CNT_W-1:0]  count_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [ADDR_W-1:0] wb_addr_i,
  output logic              legal_o
);
  logic count_ok, align_ok, op_ok;

  always_comb begin
    count_ok = (count_i != '0) && (count_i <= CNT_W'(MAX_CNT));
    align_ok = (rd_addr_i[WORD_BYTES_LOG2-1:0] == '0) &&
               (wb_addr_i[WORD_BYTES_LOG2-1:0] == '0);
    op_ok    = (op_i == OP_W'(FOLD_MIN_CODE));
    legal_o  = count_ok && align_ok && op_ok;
  end
endmodule

// File: rtl/sem_min_fold.sv
module sem_min_fold #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic              first_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] acc_o,
  output logic [DATA_W-1:0] acc_next_o
);
  logic [DATA_W-1:0] acc_q;

  // unsigned compare; first word seeds the accumulator
  always_comb begin
    if (first_i)             acc_next_o = data_i;
    else if (data_i < acc_q) acc_next_o = data_i;
    else                     acc_next_o = acc_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (clr_i)  acc_q <= '0;
    else if (en_i)   acc_q <= acc_next_o;
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/sem_seq_ctrl.sv
module sem_seq_ctrl
  import sem_pollmin_pkg::*;
#(
  parameter int MAX_CNT = 16,
  parameter int CNT_W   = 5,
  parameter int IDX_W   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_fire_i,
  input  logic             cmd_legal_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             rsp_i,
  input  logic             fold_zero_i,
  input  logic             done_ack_i,
  output eng_state_e       state_o,
  output logic [IDX_W-1:0] idx_o
);
  eng_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             last;

  assign last = ((CNT_W'(idx_q) + CNT_W'(1)) == count_i);

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_fire_i) begin
          idx_d   = '0;
          state_d = cmd_legal_i ? ST_READ : ST_DONE;
        end
      end
      ST_READ: begin
        if (rsp_i) begin
          if (last) begin
            idx_d   = '0;
            state_d = fold_zero_i ? ST_DONE : ST_WRITE;
          end else begin
            idx_d = idx_q + IDX_W'(1);
          end
        end
      end
      ST_WRITE: begin
        if (rsp_i) begin
          if (last) state_d = ST_DONE;
          else      idx_d   = idx_q + IDX_W'(1);
        end
      end
      ST_DONE: begin
        if (done_ack_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  assign state_o = state_q;
  assign idx_o   = idx_q;
endmodule

// File: rtl/sem_pollmin_engine.sv
module sem_pollmin_engine
  import sem_pollmin_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int MAX_CNT = 16,
  parameter int OP_W    = 8,
  parameter int REG_W   = 4,
  localparam int CNT_W  = $clog2(MAX_CNT + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [ADDR_W-1:0] cmd_rd_addr_i,
  input  logic [ADDR_W-1:0] cmd_wb_addr_i,
  input  logic [CNT_W-1:0]  cmd_count_i,
  input  logic [OP_W-1:0]   cmd_op_i,
  input  logic [REG_W-1:0]  cmd_reg_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_rsp_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              done_valid_o,
  input  logic              done_ready_i,
  output logic [DATA_W-1:0] done_result_o,
  output logic [REG_W-1:0]  done_reg_o,
  output logic              done_err_o
);
  localparam int IDX_W = (MAX_CNT > 1) ? $clog2(MAX_CNT) : 1;

  eng_state_e        state;
  logic [IDX_W-1:0]  idx;
  logic              cmd_fire, cmd_legal;
  logic [ADDR_W-1:0] rd_base_q, wb_base_q, offset;
  logic [CNT_W-1:0]  cnt_q;
  logic [REG_W-1:0]  reg_q;
  logic              err_q;
  logic [DATA_W-1:0] acc, acc_next;
  logic              fold_en;

  assign cmd_ready_o = (state == ST_IDLE);
  assign cmd_fire    = cmd_valid_i && cmd_ready_o;

  sem_cmd_check #(
    .ADDR_W (ADDR_W),
    .MAX_CNT(MAX_CNT),
    .OP_W   (OP_W),
    .CNT_W  (CNT_W)
  ) u_check (
    .count_i  (cmd_count_i),
    .op_i     (cmd_op_i),
    .rd_addr_i(cmd_rd_addr_i),
    .wb_addr_i(cmd_wb_addr_i),
    .legal_o  (cmd_legal)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_base_q <= '0;
      wb_base_q <= '0;
      cnt_q     <= '0;
      reg_q     <= '0;
      err_q     <= 1'b0;
    end else if (cmd_fire) begin
      rd_base_q <= cmd_rd_addr_i;
      wb_base_q <= cmd_wb_addr_i;
      cnt_q     <= cmd_count_i;
      reg_q     <= cmd_reg_i;
      err_q     <= !cmd_legal;
    end
  end

  assign fold_en = (state == ST_READ) && mem_rsp_i;

  sem_min_fold #(.DATA_W(DATA_W)) u_fold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (cmd_fire),
    .en_i      (fold_en),
    .first_i   (idx == '0),
    .data_i    (mem_rdata_i),
    .acc_o     (acc),
    .acc_next_o(acc_next)
  );

  sem_seq_ctrl #(
    .MAX_CNT(MAX_CNT),
    .CNT_W  (CNT_W),
    .IDX_W  (IDX_W)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_fire_i (cmd_fire),
    .cmd_legal_i(cmd_legal),
    .count_i    (cnt_q),
    .rsp_i      (mem_rsp_i),
    .fold_zero_i(acc_next == '0),
    .done_ack_i (done_ready_i),
    .state_o    (state),
    .idx_o      (idx)
  );

  assign offset        = ADDR_W'(idx) << WORD_BYTES_LOG2;
  assign mem_req_o     = (state == ST_READ) || (state == ST_WRITE);
  assign mem_we_o      = (state == ST_WRITE);
  assign mem_addr_o    = (mem_we_o ? wb_base_q : rd_base_q) + offset;
  assign mem_wdata_o   = acc;

  assign done_valid_o  = (state == ST_DONE);
  assign done_result_o = err_q ? '0 : acc;
  assign done_reg_o    = reg_q;
  assign done_err_o    = err_q;
endmodule

// File: rtl/sem_pollmin_checker.sv
module sem_pollmin_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int REG_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_ready_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic              mem_rsp_i,
  input logic              done_valid_o,
  input logic              done_ready_i,
  input logic [DATA_W-1:0] done_result_o,
  input logic [REG_W-1:0]  done_reg_o,
  input logic              done_err_o
);
  assert_req_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rsp_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

  assert_wb_nonzero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> mem_wdata_o != '0);

  assert_err_no_access_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_valid_o) && done_err_o |-> $past(cmd_ready_o));

  assert_done_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_valid_o && !done_ready_i |=> done_valid_o && $stable(done_result_o)
      && $stable(done_reg_o) && $stable(done_err_o));

  assert_idle_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o |-> !mem_req_o && !done_valid_o);
endmodule

bind sem_pollmin_engine sem_pollmin_checker #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W),
  .REG_W (REG_W)
) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cmd_ready_o  (cmd_ready_o),
  .mem_req_o    (mem_req_o),
  .mem_we_o     (mem_we_o),
  .mem_addr_o   (mem_addr_o),
  .mem_wdata_o  (mem_wdata_o),
  .mem_rsp_i    (mem_rsp_i),
  .done_valid_o (done_valid_o),
  .done_ready_i (done_ready_i),
  .done_result_o(done_result_o),
  .done_reg_o   (done_reg_o),
  .done_err_o   (done_err_o)
);

// File: tb/sem_pollmin_engine_tb_top.sv
`timescale 1ns/1ps
module sem_pollmin_engine_tb_top;
  localparam int NVEC = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [31:0] cmd_rd = '0, cmd_wb = '0;
  logic [4:0]  cmd_cnt = '0;
  logic [7:0]  cmd_op = '0;
  logic [3:0]  cmd_reg = '0;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_rsp = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        done_valid, done_err;
  logic        done_ready = 1'b0;
  logic [31:0] done_result;
  logic [3:0]  done_reg;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  sem_pollmin_engine dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_rd_addr_i(cmd_rd), .cmd_wb_addr_i(cmd_wb),
    .cmd_count_i(cmd_cnt), .cmd_op_i(cmd_op), .cmd_reg_i(cmd_reg),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rsp_i(mem_rsp), .mem_rdata_i(mem_rdata),
    .done_valid_o(done_valid), .done_ready_i(done_ready),
    .done_result_o(done_result), .done_reg_o(done_reg), .done_err_o(done_err)
  );

  // {count[4:0], op[7:0], rd_addr[7:0], wb_addr[7:0], pattern[2:0]}
  localparam logic [31:0] VEC [NVEC] = '{
    {5'd6,  8'h09, 8'h00, 8'h80, 3'd0},
    {5'd1,  8'h09, 8'h20, 8'h40, 3'd1},
    {5'd16, 8'h09, 8'h40, 8'hC0, 3'd2},
    {5'd4,  8'h09, 8'h20, 8'h60, 3'd3},
    {5'd0,  8'h09, 8'h00, 8'h80, 3'd1},
    {5'd17, 8'h09, 8'h00, 8'h80, 3'd1},
    {5'd3,  8'h08, 8'h00, 8'h80, 3'd1},
    {5'd3,  8'h09, 8'h22, 8'h80, 3'd1},
    {5'd3,  8'h09, 8'h00, 8'h81, 3'd1},
    {5'd5,  8'h09, 8'h50, 8'hA0, 3'd4}
  };

  function automatic logic [31:0] word_f(int pat, int j);
    case (pat)
      0: case (j)
           0: return 32'd8;  1: return 32'd3;  2: return 32'd5;
           3: return 32'd4;  4: return 32'd4;  5: return 32'd10;
           default: return 32'd77;
         endcase
      1: return 32'h1234 + 32'(j);
      2: return 32'h0100_0000 - 32'(j * j * 3) + 32'((j % 5) * 7);
      3: return (j == 9) ? 32'd0 : 32'(50 + j);
      4: return (j % 2 == 1) ? 32'hFFFF_FFF0 - 32'(j) : 32'h8000_0000 + 32'(j);
      default: return 32'(j + 1);
    endcase
  endfunction

  // memory model: one response per request, a cycle after it is seen
  logic [31:0] mem [64];
  logic [7:0]  rd_log [32];
  int          rd_cnt = 0, wr_cnt = 0;
  logic        fill_go = 1'b0;
  int          fill_pat = 0;

  always @(posedge clk) begin
    if (fill_go) begin
      for (int j = 0; j < 64; j++) mem[j] <= word_f(fill_pat, j);
      rd_cnt  <= 0;
      wr_cnt  <= 0;
      mem_rsp <= 1'b0;
    end else if (mem_req && !mem_rsp) begin
      mem_rsp <= 1'b1;
      if (mem_we) begin
        mem[mem_addr[7:2]] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
      end else begin
        mem_rdata <= mem[mem_addr[7:2]];
        if (rd_cnt < 32) rd_log[rd_cnt] <= mem_addr[7:0];
        rd_cnt <= rd_cnt + 1;
      end
    end else begin
      mem_rsp <= 1'b0;
    end
  end

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic fill(int pat);
    @(negedge clk);
    fill_pat = pat;
    fill_go  = 1'b1;
    @(negedge clk);
    fill_go  = 1'b0;
  endtask

  task automatic send(logic [4:0] c, logic [7:0] op, logic [31:0] rd, logic [31:0] wb,
                      logic [3:0] rg);
    cmd_cnt = c; cmd_op = op; cmd_rd = rd; cmd_wb = wb; cmd_reg = rg;
    cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done();
    while (!done_valid) @(negedge clk);
  endtask

  task automatic ack();
    done_ready = 1'b1;
    @(negedge clk);
    done_ready = 1'b0;
  endtask

  task automatic run_vec(int v);
    logic [4:0]  c;
    logic [7:0]  op, rd, wb;
    int          pat, n, rb, wbi;
    bit          legal;
    logic [31:0] mn, expw;
    c = VEC[v][31:27]; op = VEC[v][26:19]; rd = VEC[v][18:11];
    wb = VEC[v][10:3]; pat = int'(VEC[v][2:0]);
    legal = (c >= 1) && (c <= 16) && (rd[1:0] == 0) && (wb[1:0] == 0) && (op == 8'h09);
    n = (c > 16) ? 16 : int'(c);
    rb = int'(rd[7:2]); wbi = int'(wb[7:2]);
    mn = '1;
    for (int k = 0; k < n; k++) if (word_f(pat, rb + k) < mn) mn = word_f(pat, rb + k);
    if (!legal) mn = '0;
    fill(pat);
    @(negedge clk);
    send(c, op, {24'h0, rd}, {24'h0, wb}, 4'(v));
    wait_done();
    chk(done_err == !legal, $sformatf("R2 err v%0d", v), 32'(done_err), 32'(!legal));
    chk(done_result == mn, $sformatf("R4 result v%0d", v), done_result, mn);
    chk(done_reg == 4'(v), $sformatf("R7 reg v%0d", v), 32'(done_reg), 32'(v));
    chk(rd_cnt == (legal ? n : 0), $sformatf("R3 reads v%0d", v), 32'(rd_cnt), 32'(legal ? n : 0));
    if (legal)
      for (int k = 0; k < n; k++)
        chk(rd_log[k] == rd + 8'(4 * k), $sformatf("R3 order v%0d k%0d", v, k),
            32'(rd_log[k]), 32'(rd + 8'(4 * k)));
    chk(wr_cnt == ((legal && mn != 0) ? n : 0), $sformatf("R5 R6 writes v%0d", v),
        32'(wr_cnt), 32'((legal && mn != 0) ? n : 0));
    for (int k = 0; k < n; k++) begin
      expw = (legal && mn != 0) ? mn : word_f(pat, wbi + k);
      chk(mem[wbi + k] == expw, $sformatf("R5 R6 wbword v%0d k%0d", v, k), mem[wbi + k], expw);
    end
    ack();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog act=hung exp=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cmd_ready == 1'b1, "R1 ready", 32'(cmd_ready), 1);
    chk(mem_req == 1'b0, "R1 req", 32'(mem_req), 0);
    chk(done_valid == 1'b0, "R1 done", 32'(done_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 R5 R6 R9 table walk (v1 count 1, v2 count 16)
    for (int v = 0; v < NVEC; v++) run_vec(v);

    // R8 command offered while busy is never taken
    fill(1);
    send(5'd8, 8'h09, 32'h00, 32'h80, 4'd3);
    cmd_cnt = 5'd0; cmd_reg = 4'd15; cmd_valid = 1'b1;
    repeat (4) @(negedge clk);
    chk(cmd_ready == 1'b0, "R8 busy", 32'(cmd_ready), 0);
    cmd_valid = 1'b0;
    wait_done();
    chk(done_reg == 4'd3, "R8 first reg", 32'(done_reg), 3);
    chk(done_result == 32'h1234, "R4 busy result", done_result, 32'h1234);
    ack();
    repeat (6) @(negedge clk);
    chk(done_valid == 1'b0, "R8 no extra done", 32'(done_valid), 0);
    chk(rd_cnt == 8, "R8 no extra reads", 32'(rd_cnt), 8);

    // R7 R8 completion held, then ack and new command in same cycle
    fill(1);
    send(5'd2, 8'h09, 32'h10, 32'h40, 4'd5);
    wait_done();
    repeat (5) @(negedge clk);
    chk(done_valid && done_reg == 4'd5, "R7 held", 32'(done_valid), 1);
    chk(done_result == 32'h1238, "R7 result", done_result, 32'h1238);
    cmd_cnt = 5'd1; cmd_op = 8'h09; cmd_rd = 32'h0C; cmd_wb = 32'h44; cmd_reg = 4'd7;
    cmd_valid = 1'b1;
    done_ready = 1'b1;
    chk(cmd_ready == 1'b0, "R8 ready during ack", 32'(cmd_ready), 0);
    @(negedge clk);
    done_ready = 1'b0;
    chk(cmd_ready == 1'b1, "R8 ready after ack", 32'(cmd_ready), 1);
    chk(done_valid == 1'b0, "R7 done dropped", 32'(done_valid), 0);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(cmd_ready == 1'b0, "R8 taken", 32'(cmd_ready), 0);
    wait_done();
    chk(done_reg == 4'd7, "R7 second reg", 32'(done_reg), 7);
    chk(done_result == 32'h1237, "R9 single result", done_result, 32'h1237);
    chk(mem[17] == 32'h1237, "R5 single write", mem[17], 32'h1237);
    ack();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule